// File: doc/BRIEF.md
# Oversampled Manchester Line Receiver with Start-of-Frame Framing

This block turns a 10 Mb/s Manchester-coded serial line into bytes. It samples the line on a synchronous clock running `OSR` times the bit rate (80 MHz at the default of 8). The line goes through a short synchronizer. A cycle counter then measures the distance from one accepted centre transition to the next. While the receiver is tracking, it accepts a transition only if it lands within `TOL` samples of the expected bit centre. This window rejects the extra transitions that sit on cell boundaries, and it also rejects short glitches.

After `LOCK_EDGES` accepted centre transitions in a row the receiver reports lock. The alternating preamble ends with two ones in a row. When lock is held and the two newest decoded bits are both one, a frame opens. Every later decoded bit then goes into a byte shift register, least significant bit first. A byte counter wraps after `BYTE_W` bits. One bit period after a byte completes, a one-cycle strobe marks that byte as valid on the parallel output.

When transitions stop between packets, tracking lapses. Lock and the frame flag then fall, and the receiver hunts again for the next preamble.

Top module: `mrx_rx`

## Requirements
- R1: A logic 0 is a high half-cell followed by a low half-cell, and a logic 1 is low then high. The decoded bit value is the line level just after the accepted centre transition.
- R2: While tracking, the receiver accepts a transition only if it arrives between `OSR-TOL` and `OSR+TOL` samples after the previous accepted one. Cell-boundary transitions, and glitches one or two samples after a centre, change no decoded bit and shift no byte timing.
- R3: Starting from an idle line, `lock_o` stays low through the 15th accepted centre transition and is high once the 16th (`LOCK_EDGES`) has been taken. It rises only in the cycle after an accepted transition.
- R4: If no transition is accepted for `LOSS_CELLS*OSR` cycles (16), `lock_o` falls, and `frame_o` is never high while `lock_o` is low.
- R5: `frame_o` stays low through the alternating preamble. It rises only with lock held, after two successive decoded ones, and stays high while lock remains.
- R6: The first bit decoded after the two-ones marker is bit 0 of the first byte. Each byte on `byte_o` holds its bits in arrival order, from bit 0 upward.
- R7: `strobe_o` is high for exactly one cycle, `OSR` cycles after the last bit of a byte is accepted. `byte_o` is unchanged in the strobe cycle. With no jitter, strobes within a frame are `BYTE_W*OSR` (64) cycles apart.
- R8: A strobe occurs only for a complete byte inside an open frame. A trailing partial byte and a burst too short to gain lock produce no strobe.
- R9: Centre transitions displaced by up to ±1 sample from one cell to the next still decode every byte correctly.
- R10: After an idle gap the receiver regains lock on a fresh preamble and decodes the next frame.
- R11: After reset, `lock_o`, `frame_o`, `strobe_o` and `byte_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, OSR times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Asynchronous Manchester line sample |
| byte_o | output | BYTE_W | Last completed byte, bit 0 first received |
| strobe_o | output | 1 | One-cycle pulse: byte_o holds a new byte |
| frame_o | output | 1 | Frame open after the start-of-frame marker |
| lock_o | output | 1 | Bit timing locked |

## Verification
The checker watches four things on every cycle. It checks that accepted transitions under lock always fall within the ±TOL window of the previous centre. It checks that lock falls once the silent span passes the loss limit, and that lock rises only after an accepted transition. It also checks that the frame flag rises only under lock, and that strobes are single-cycle, arrive inside a frame and leave the byte steady.

Other properties need the bench's scenarios. These are the exact lock threshold, the bit order and byte values across a full sweep of all 256 byte codes, and the 64-cycle strobe spacing. The bench scenarios also cover tolerance to jitter and glitches, the loss of a partial byte, the refusal of a short burst, and reacquisition after idle.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
   // one decoded bit event from the timing tracker to the framer
   typedef struct packed {
      logic valid;
      logic value;
   } mrx_bit_t;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk)
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mrx_track.sv
module mrx_track
   import mrx_pkg::*;
#(
   parameter int OSR        = 8,
   parameter int TOL        = 2,
   parameter int LOCK_EDGES = 16,
   parameter int LOSS_CELLS = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     samp_i,
   output mrx_bit_t bit_o,
   output logic     track_o,
   output logic     lock_o
);
   localparam int LIMIT = LOSS_CELLS * OSR;
   localparam int SW    = $clog2(LIMIT + 1);
   localparam int RW    = $clog2(LOCK_EDGES + 1);
   localparam logic [SW-1:0] LIM_C  = SW'(LIMIT);
   localparam logic [SW-1:0] WIN_LO = SW'(OSR - TOL - 1);
   localparam logic [SW-1:0] WIN_HI = SW'(OSR + TOL - 1);
   localparam logic [RW-1:0] RUN_C  = RW'(LOCK_EDGES);

   logic          prev_q;
   logic [SW-1:0] since_q;   // cycles since the last accepted centre
   logic [RW-1:0] run_q;     // consecutive accepted centres
   logic          edge_w, in_win, take;

   assign edge_w  = samp_i ^ prev_q;
   assign track_o = (since_q < LIM_C);
   assign in_win  = (since_q >= WIN_LO) && (since_q <= WIN_HI);
   assign take    = edge_w && (!track_o || in_win);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         since_q <= LIM_C;
         run_q   <= '0;
      end else begin
         prev_q <= samp_i;
         if (take)
            since_q <= '0;
         else if (track_o)
            since_q <= since_q + 1'b1;
         if (take)
            run_q <= !track_o ? RW'(1) : ((run_q == RUN_C) ? run_q : run_q + 1'b1);
         else if (!track_o)
            run_q <= '0;
      end
   end

   assign lock_o      = track_o && (run_q >= RUN_C);
   assign bit_o.valid = take;
   assign bit_o.value = samp_i;
endmodule

// File: rtl/mrx_frame.sv
module mrx_frame
   import mrx_pkg::*;
#(
   parameter int OSR       = 8,
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mrx_bit_t          bit_i,
   input  logic              track_i,
   input  logic              lock_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              strobe_o,
   output logic              frame_o
);
   localparam int CW = $clog2(BYTE_W);
   localparam int DW = $clog2(OSR + 1);
   localparam logic [CW-1:0] LAST_C = CW'(BYTE_W - 1);

   logic [1:0]        hist_q;
   logic              frame_q;
   logic [CW-1:0]     cnt_q;
   logic [BYTE_W-1:0] sh_q, sh_nx, byte_q;
   logic [DW-1:0]     dly_q;
   logic              gate_w, done_w;

   if (LSB_FIRST) begin : g_lsb
      assign sh_nx = {bit_i.value, sh_q[BYTE_W-1:1]};
   end else begin : g_msb
      assign sh_nx = {sh_q[BYTE_W-2:0], bit_i.value};
   end

   assign gate_w = frame_q && (cnt_q == LAST_C);
   assign done_w = gate_w && bit_i.valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q  <= '0;
         frame_q <= 1'b0;
         cnt_q   <= '0;
         sh_q    <= '0;
         byte_q  <= '0;
         dly_q   <= '0;
      end else begin
         if (!track_i)
            hist_q <= '0;
         else if (bit_i.valid)
            hist_q <= {hist_q[0], bit_i.value};
         frame_q <= lock_i && (frame_q || (hist_q == 2'b11));
         if (!frame_q)
            cnt_q <= '0;
         else if (bit_i.valid) begin
            sh_q  <= sh_nx;
            cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
         end
         if (done_w) begin
            byte_q <= sh_nx;
            dly_q  <= DW'(OSR);
         end else if (dly_q != '0)
            dly_q <= dly_q - 1'b1;
      end
   end

   assign byte_o   = byte_q;
   assign strobe_o = (dly_q == DW'(1));
   assign frame_o  = frame_q && lock_i;
endmodule

// File: rtl/mrx_rx.sv
module mrx_rx
   import mrx_pkg::*;
#(
   parameter int OSR         = 8,
   parameter int TOL         = 2,
   parameter int LOCK_EDGES  = 16,
   parameter int LOSS_CELLS  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              strobe_o,
   output logic              frame_o,
   output logic              lock_o
);
   if (OSR < 4) begin : g_bad_osr
      $error("mrx_rx: OSR must be at least 4");
   end
   if (TOL < 1 || 2 * TOL >= OSR) begin : g_bad_tol
      $error("mrx_rx: TOL must lie in 1 .. OSR/2-1");
   end
   if (LOSS_CELLS < 2 || LOCK_EDGES < 2) begin : g_bad_cnt
      $error("mrx_rx: LOSS_CELLS and LOCK_EDGES must be at least 2");
   end
   if (SYNC_STAGES < 2 || BYTE_W < 2) begin : g_bad_w
      $error("mrx_rx: SYNC_STAGES and BYTE_W must be at least 2");
   end

   logic     samp_w, track_w, lock_w, acc_w;
   mrx_bit_t bit_w;

   mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(samp_w));

   mrx_track #(.OSR(OSR), .TOL(TOL), .LOCK_EDGES(LOCK_EDGES),
               .LOSS_CELLS(LOSS_CELLS)) u_track (
      .clk(clk), .rst_n(rst_n), .samp_i(samp_w), .bit_o(bit_w),
      .track_o(track_w), .lock_o(lock_w));

   mrx_frame #(.OSR(OSR), .BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_frame (
      .clk(clk), .rst_n(rst_n), .bit_i(bit_w), .track_i(track_w),
      .lock_i(lock_w), .byte_o(byte_o), .strobe_o(strobe_o),
      .frame_o(frame_o));

   assign acc_w  = bit_w.valid;
   assign lock_o = lock_w;
endmodule

// File: rtl/mrx_rx_chk.sv
module mrx_rx_chk #(
   parameter int OSR        = 8,
   parameter int TOL        = 2,
   parameter int LOSS_CELLS = 2,
   parameter int BYTE_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lock,
   input logic              frame,
   input logic              strobe,
   input logic [BYTE_W-1:0] byte_v,
   input logic              bit_ev
);
   localparam int LIMIT = LOSS_CELLS * OSR;
   localparam int GW    = $clog2(LIMIT + 2);
   localparam logic [GW-1:0] GMAX = GW'(LIMIT + 1);

   // independent count of cycles since the previous accepted transition
   logic [GW-1:0] gap_q;
   always_ff @(posedge clk)
      if (!rst_n)      gap_q <= GMAX;
      else if (bit_ev) gap_q <= GW'(1);
      else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;

   // R2
   win_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && bit_ev) |-> (gap_q >= GW'(OSR - TOL) && gap_q <= GW'(OSR + TOL)));
   // R4
   lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q > GW'(LIMIT)) |-> !lock);
   // R3
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> $past(bit_ev));
   // R5
   frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame) |-> $past(lock));
   // R7
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
   // R7
   strobe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> $stable(byte_v));
   // R8
   strobe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> frame);
endmodule

bind mrx_rx mrx_rx_chk #(.OSR(OSR), .TOL(TOL), .LOSS_CELLS(LOSS_CELLS),
                         .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lock(lock_o), .frame(frame_o),
   .strobe(strobe_o), .byte_v(byte_o), .bit_ev(acc_w));

// File: tb/mrx_rx_test.sv
`timescale 1ns/1ps
module mrx_rx_test;
   localparam int OSR  = 8;
   localparam int HALF = OSR / 2;
   localparam int NMAX = 600;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line = 1'b0;
   logic [7:0] byte_o;
   logic       strobe, frame, lock;

   mrx_rx uut (.clk(clk), .rst_n(rst_n), .line_i(line), .byte_o(byte_o),
               .strobe_o(strobe), .frame_o(frame), .lock_o(lock));

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   int cycle = 0;
   int pkt = 0;
   bit done = 0;
   int n_exp = 0, n_got = 0;
   logic [7:0] exp_b [NMAX];
   int         exp_p [NMAX];
   bit         exp_g [NMAX];
   logic [7:0] got_b [NMAX];
   int         got_c [NMAX];
   int         got_p [NMAX];
   bit         frame_seen = 0;
   int         jit_ph = 0;

   always @(posedge clk) cycle <= cycle + 1;

   always @(negedge clk) begin
      if (rst_n && frame) frame_seen = 1;
      if (rst_n && strobe && n_got < NMAX) begin
         got_b[n_got] = byte_o;
         got_c[n_got] = cycle;
         got_p[n_got] = pkt;
         n_got++;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic drive(input logic lv, input int n);
      line = lv;
      repeat (n) @(negedge clk);
   endtask

   // mode 0 plain, 1 jittered centre, 2 glitch after centre
   task automatic send_bit(input logic b, input int mode);
      int j;
      j = 0;
      if (mode == 1) begin
         j = (jit_ph == 0) ? 0 : ((jit_ph == 1) ? 1 : -1);
         jit_ph = (jit_ph + 1) % 3;
      end
      if (mode == 2) begin
         drive(!b, HALF); drive(b, 1); drive(!b, 1); drive(b, HALF - 2);
      end else begin
         drive(!b, HALF + j); drive(b, HALF - j);
      end
   endtask

   task automatic send_byte(input logic [7:0] v, input int mode, input bit gchk);
      if (n_exp < NMAX) begin
         exp_b[n_exp] = v; exp_p[n_exp] = pkt; exp_g[n_exp] = gchk; n_exp++;
      end
      for (int i = 0; i < 8; i++) send_bit(v[i], mode);
   endtask

   task automatic preamble_alt(input int n);
      for (int i = 0; i < n; i++) send_bit((i % 2) == 0, 0);
   endtask

   task automatic idle_gap();
      repeat (40) @(negedge clk);
      line = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(lock == 0,   "R11 lock after reset", int'(lock), 0);
      check(frame == 0,  "R11 frame after reset", int'(frame), 0);
      check(strobe == 0, "R11 strobe after reset", int'(strobe), 0);
      check(byte_o == 0, "R11 byte after reset", int'(byte_o), 0);
      repeat (20) @(negedge clk);

      // packet 1: lock threshold, marker, plain bytes
      pkt = 1;
      preamble_alt(15);
      check(lock == 0, "R3 lock after 15 centres", int'(lock), 0);
      send_bit(1'b0, 0);
      check(lock == 1, "R3 lock after 16 centres", int'(lock), 1);
      preamble_alt(46);   // continues 1,0,... : 62 alternating bits in total
      check(frame == 0, "R5 frame during preamble", int'(frame), 0);
      check(frame_seen == 0, "R5 no frame before marker", int'(frame_seen), 0);
      send_bit(1'b1, 0); send_bit(1'b1, 0);
      send_byte(8'hFF, 0, 1);
      check(frame == 1, "R5 frame after marker", int'(frame), 1);
      send_byte(8'h00, 0, 1);
      send_byte(8'hA5, 0, 1);
      send_byte(8'h3C, 0, 1);
      send_byte(8'h01, 0, 1);
      send_byte(8'h80, 0, 1);
      repeat (10) @(negedge clk);
      check(lock == 1, "R4 lock held shortly after last bit", int'(lock), 1);
      repeat (20) @(negedge clk);
      check(lock == 0,  "R4 lock dropped after silence", int'(lock), 0);
      check(frame == 0, "R4 frame cleared with lock", int'(frame), 0);
      idle_gap();

      // packet 2: every byte code with centre jitter
      pkt = 2;
      preamble_alt(62); send_bit(1'b1, 0); send_bit(1'b1, 0);
      for (int v = 0; v < 256; v++) send_byte(8'(v), 1, 0);
      idle_gap();
      check(lock == 0, "R10 idle after jitter frame", int'(lock), 0);

      // packet 3: glitches after each centre
      pkt = 3;
      preamble_alt(62); send_bit(1'b1, 0); send_bit(1'b1, 0);
      for (int v = 0; v < 16; v++) send_byte(8'(v * 17 + 3), 2, 1);
      idle_gap();

      // packet 4: one full byte then a partial one
      pkt = 4;
      preamble_alt(62); send_bit(1'b1, 0); send_bit(1'b1, 0);
      send_byte(8'h5A, 0, 1);
      send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
      idle_gap();

      // packet 5: burst too short to lock
      pkt = 5;
      frame_seen = 0;
      send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b1, 0);
      for (int i = 0; i < 8; i++) send_bit(i < 4, 0);
      idle_gap();
      check(frame_seen == 0, "R8 short burst opens no frame", int'(frame_seen), 0);

      // compare strobed bytes
      check(n_got == n_exp, "R8 strobe count equals complete bytes", n_got, n_exp);
      for (int k = 0; k < n_exp && k < n_got; k++) begin
         if (exp_p[k] == 2)
            check(got_b[k] == exp_b[k], "R9 jittered byte value", int'(got_b[k]), int'(exp_b[k]));
         else if (exp_p[k] == 3)
            check(got_b[k] == exp_b[k], "R2 glitched byte value", int'(got_b[k]), int'(exp_b[k]));
         else
            check(got_b[k] == exp_b[k], "R6 R1 byte value", int'(got_b[k]), int'(exp_b[k]));
         check(got_p[k] == exp_p[k], "R10 byte in its frame", got_p[k], exp_p[k]);
         if (k > 0 && exp_g[k] && exp_g[k-1] && exp_p[k] == exp_p[k-1])
            check(got_c[k] - got_c[k-1] == 8 * OSR, "R7 strobe spacing",
                  got_c[k] - got_c[k-1], 8 * OSR);
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cycle, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule